// File: doc/BRIEF.md
# Event-Driven Module Clock Controller

This block lets one converter-style peripheral run a single operation while the rest of the chip stays asleep. It runs from an always-on clock. It accepts an asynchronous event from a periodic timer or from a PWM source and brings that event into its own domain. When the peripheral's trigger-mode code selects routed events, or when a software or hardware trigger matches the code, the block turns on the clock for that peripheral alone. If the shared clock source is stopped in the current sleep mode, the block first requests the source and waits for it to report ready.

The block issues one start pulse and keeps the module clock enabled while the peripheral reports busy. It then gates the clock off and releases the source. It never touches the system sleep state. The only way it reaches the CPU is a wake level, which it raises when the peripheral interrupts during or at the end of the operation. A trigger that arrives while an operation is in flight is kept pending and served straight after the current one, without releasing the source in between.

Top module: `evc_clk_ctrl`

## Requirements
- R1: When `trig_mode` is 3'b111, a rising edge on the selected asynchronous event starts exactly one conversion. `evt_sel`=0 selects the timer event and `evt_sel`=1 selects the PWM event.
- R2: A timer event has no effect while `tmr_evt_en` is 0. An event from the source that `evt_sel` does not select also has no effect.
- R3: When `trig_mode` is 3'b000, a one-cycle `sw_trig` pulse starts exactly one conversion. Events and `hw_trig` are ignored in this mode.
- R4: When `trig_mode` is any value from 3'b001 to 3'b110, a one-cycle `hw_trig` pulse starts exactly one conversion. Events and `sw_trig` are ignored in these modes.
- R5: If `src_running` is 0 when a trigger is served, `src_req` rises first, and neither `conv_start` nor `mod_clk_en` is asserted until `src_ready` is 1. If `src_running` is 1, `src_req` stays 0.
- R6: `mod_clk_en` is 1 from the start pulse while `conv_busy` is 1, and it returns to 0 once `conv_busy` falls.
- R7: A trigger that arrives during an operation is served right after that operation completes, and `src_req` stays high continuously across both operations.
- R8: `wake` rises when `conv_irq` is high during an operation or at its completion. It stays high until `wake_clr` is pulsed, and it never rises without `conv_irq`.
- R9: After reset, `src_req`, `mod_clk_en`, `conv_start` and `wake` are all 0.
- R10: `conv_start` is a single-cycle pulse for each conversion that is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_timer_a | input | 1 | Asynchronous periodic timer event |
| evt_pwm_a | input | 1 | Asynchronous PWM event |
| tmr_evt_en | input | 1 | Enables the timer event |
| evt_sel | input | 1 | Event source select: 0 timer, 1 PWM |
| trig_mode | input | 3 | Trigger-mode code: 0 software, 1..6 hardware, 7 routed event |
| sw_trig | input | 1 | Software trigger pulse |
| hw_trig | input | 1 | Hardware trigger pulse |
| src_running | input | 1 | Clock source is already running in this sleep mode |
| src_ready | input | 1 | Clock source reports stable |
| src_req | output | 1 | Request to restart and hold the clock source |
| mod_clk_en | output | 1 | Clock gate enable for the peripheral |
| conv_start | output | 1 | One-cycle conversion start |
| conv_busy | input | 1 | Peripheral operation in progress |
| conv_irq | input | 1 | Peripheral interrupt request |
| wake | output | 1 | System wake level |
| wake_clr | input | 1 | Clears the wake level |

## Verification
On every cycle, the assertions check four things: the start pulse lasts one cycle, the module clock is never enabled on a stopped source that is not yet ready, the gate closes only after busy has dropped, and the source is released only with the gate closed. They also check that wake is held until it is cleared and rises only after an interrupt. The bench scenarios cover the rest. They sweep all eight trigger-mode codes against each trigger kind, with the source both running and stopped, and count the conversions. Other scenarios show that a trigger arriving mid-operation is served without a drop of the source request, and that a disabled or unselected event source has no effect.

// File: rtl/evc_pkg.sv
package evc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_REQ_SRC  = 3'd1,
        ST_WAIT_RDY = 3'd2,
        ST_START    = 3'd3,
        ST_BUSY     = 3'd4,
        ST_RELEASE  = 3'd5
    } evc_state_e;

    typedef struct packed {
        evc_state_e state;
        logic       src_hold;
        logic       wake;
    } evc_seq_t;

endpackage

// File: rtl/evc_sync.sv
module evc_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.chain = {r_q.chain[STAGES-2:0], async_i};
        r_d.last  = r_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rise_o = r_q.chain[STAGES-1] & ~r_q.last;
endmodule

// File: rtl/evc_trig_sel.sv
module evc_trig_sel #(
    parameter int unsigned          MODE_W   = 3,
    parameter logic [MODE_W-1:0]    EVT_CODE = '1,
    parameter logic [MODE_W-1:0]    SW_CODE  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              evt_i,
    input  logic              sw_i,
    input  logic              hw_i,
    input  logic              consume_i,
    output logic              pend_o
);
    logic pend_d, pend_q;
    logic fire;

    always_comb begin
        if (mode_i == EVT_CODE)     fire = evt_i;
        else if (mode_i == SW_CODE) fire = sw_i;
        else                        fire = hw_i;
        // A fresh trigger wins over the consume of an older one.
        pend_d = fire | (pend_q & ~consume_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/evc_seq.sv
module evc_seq
    import evc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend_i,
    input  logic src_running_i,
    input  logic src_ready_i,
    input  logic busy_i,
    input  logic irq_i,
    input  logic wake_clr_i,
    output logic consume_o,
    output logic src_req_o,
    output logic clk_en_o,
    output logic start_o,
    output logic wake_o
);
    evc_seq_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        consume_o = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (pend_i) begin
                    if (src_running_i) begin
                        r_d.state = ST_START;
                    end else begin
                        r_d.state    = ST_REQ_SRC;
                        r_d.src_hold = 1'b1;
                    end
                end
            end
            ST_REQ_SRC:  r_d.state = ST_WAIT_RDY;
            ST_WAIT_RDY: if (src_ready_i) r_d.state = ST_START;
            ST_START: begin
                consume_o = 1'b1;
                r_d.state = ST_BUSY;
            end
            ST_BUSY:     if (!busy_i) r_d.state = ST_RELEASE;
            ST_RELEASE: begin
                if (pend_i) begin
                    r_d.state = ST_START;
                end else begin
                    r_d.state    = ST_IDLE;
                    r_d.src_hold = 1'b0;
                end
            end
            default: begin
                r_d.state    = ST_IDLE;
                r_d.src_hold = 1'b0;
            end
        endcase

        if (irq_i && (r_q.state == ST_BUSY || r_q.state == ST_RELEASE))
            r_d.wake = 1'b1;
        else if (wake_clr_i)
            r_d.wake = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE, src_hold: 1'b0, wake: 1'b0};
        else        r_q <= r_d;
    end

    assign src_req_o = r_q.src_hold;
    assign start_o   = (r_q.state == ST_START);
    assign clk_en_o  = (r_q.state == ST_START) || (r_q.state == ST_BUSY);
    assign wake_o    = r_q.wake;
endmodule

// File: rtl/evc_clk_ctrl.sv
module evc_clk_ctrl #(
    parameter int unsigned       SYNC_STAGES = 2,
    parameter int unsigned       MODE_W      = 3,
    parameter logic [MODE_W-1:0] EVT_CODE    = '1,
    parameter logic [MODE_W-1:0] SW_CODE     = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_timer_a,
    input  logic              evt_pwm_a,
    input  logic              tmr_evt_en,
    input  logic              evt_sel,
    input  logic [MODE_W-1:0] trig_mode,
    input  logic              sw_trig,
    input  logic              hw_trig,
    input  logic              src_running,
    input  logic              src_ready,
    output logic              src_req,
    output logic              mod_clk_en,
    output logic              conv_start,
    input  logic              conv_busy,
    input  logic              conv_irq,
    output logic              wake,
    input  logic              wake_clr
);
    logic evt_raw, evt_rise, pend, consume;

    assign evt_raw = evt_sel ? evt_pwm_a : (evt_timer_a & tmr_evt_en);

    evc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(evt_raw),
        .rise_o (evt_rise)
    );

    evc_trig_sel #(.MODE_W(MODE_W), .EVT_CODE(EVT_CODE), .SW_CODE(SW_CODE)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (trig_mode),
        .evt_i    (evt_rise),
        .sw_i     (sw_trig),
        .hw_i     (hw_trig),
        .consume_i(consume),
        .pend_o   (pend)
    );

    evc_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .pend_i       (pend),
        .src_running_i(src_running),
        .src_ready_i  (src_ready),
        .busy_i       (conv_busy),
        .irq_i        (conv_irq),
        .wake_clr_i   (wake_clr),
        .consume_o    (consume),
        .src_req_o    (src_req),
        .clk_en_o     (mod_clk_en),
        .start_o      (conv_start),
        .wake_o       (wake)
    );
endmodule

// File: rtl/evc_clk_ctrl_chk.sv
module evc_clk_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic src_running,
    input logic src_ready,
    input logic src_req,
    input logic mod_clk_en,
    input logic conv_start,
    input logic conv_busy,
    input logic conv_irq,
    input logic wake,
    input logic wake_clr
);
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    a_r5_ready_before_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_clk_en && !src_running) |-> src_ready);

    a_r6_gate_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mod_clk_en) |-> !$past(conv_busy));

    a_r7_release_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(src_req) |-> !mod_clk_en);

    a_r8_wake_held: assert property (@(posedge clk) disable iff (!rst_n)
        (wake && !wake_clr) |=> wake);

    a_r8_wake_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake) |-> $past(conv_irq));
endmodule

bind evc_clk_ctrl evc_clk_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_running(src_running),
    .src_ready  (src_ready),
    .src_req    (src_req),
    .mod_clk_en (mod_clk_en),
    .conv_start (conv_start),
    .conv_busy  (conv_busy),
    .conv_irq   (conv_irq),
    .wake       (wake),
    .wake_clr   (wake_clr)
);

// File: tb/evc_clk_ctrl_tb_top.sv
`timescale 1ns/1ps
module evc_clk_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic evt_timer_a = 0, evt_pwm_a = 0, tmr_evt_en = 0, evt_sel = 0;
    logic [2:0] trig_mode = 3'd7;
    logic sw_trig = 0, hw_trig = 0, src_running = 1, src_ready;
    logic src_req, mod_clk_en, conv_start, conv_busy, conv_irq, wake;
    logic wake_clr = 0, irq_on = 0;

    int n_chk = 0, n_err = 0;
    int conv_cnt = 0, srcfall_cnt = 0, srchigh_cnt = 0;
    int busy_len = 3, busy_cnt = 0, rdy_cnt = 0;
    logic rdy_q = 0, src_req_prev = 0, finished = 0;

    always #5 clk = ~clk;

    evc_clk_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .evt_timer_a(evt_timer_a), .evt_pwm_a(evt_pwm_a),
        .tmr_evt_en(tmr_evt_en), .evt_sel(evt_sel), .trig_mode(trig_mode),
        .sw_trig(sw_trig), .hw_trig(hw_trig), .src_running(src_running),
        .src_ready(src_ready), .src_req(src_req), .mod_clk_en(mod_clk_en),
        .conv_start(conv_start), .conv_busy(conv_busy), .conv_irq(conv_irq),
        .wake(wake), .wake_clr(wake_clr)
    );

    // Peripheral and oscillator models
    assign conv_busy = (busy_cnt != 0);
    assign conv_irq  = irq_on & conv_busy;
    assign src_ready = rdy_q;

    always @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= 0; rdy_cnt <= 0; rdy_q <= 0;
        end else begin
            if (conv_start)        busy_cnt <= busy_len;
            else if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
            if (!src_req) begin rdy_cnt <= 0; rdy_q <= 0; end
            else if (rdy_cnt == 4) rdy_q <= 1;
            else rdy_cnt <= rdy_cnt + 1;
            if (conv_start) conv_cnt <= conv_cnt + 1;
            if (src_req) srchigh_cnt <= srchigh_cnt + 1;
            if (src_req_prev && !src_req) srcfall_cnt <= srcfall_cnt + 1;
            src_req_prev <= src_req;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic fire_timer();
        @(negedge clk); evt_timer_a = 1;
        repeat (3) @(negedge clk); evt_timer_a = 0;
    endtask

    task automatic fire_pwm();
        @(negedge clk); evt_pwm_a = 1;
        repeat (3) @(negedge clk); evt_pwm_a = 0;
    endtask

    task automatic pulse_sw();
        @(negedge clk); sw_trig = 1; @(negedge clk); sw_trig = 0;
    endtask

    task automatic pulse_hw();
        @(negedge clk); hw_trig = 1; @(negedge clk); hw_trig = 0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int c0, f0, h0, waited;
        settle(3);
        // R9: reset state
        check(!src_req && !mod_clk_en && !conv_start && !wake, "R9 reset outputs",
              int'({src_req, mod_clk_en, conv_start, wake}), 0);
        @(negedge clk); rst_n = 1;
        settle(2);
        check(!src_req && !mod_clk_en && !conv_start && !wake, "R9 after release",
              int'({src_req, mod_clk_en, conv_start, wake}), 0);

        // R1 R3 R4 R5: sweep trigger-mode codes, trigger kinds and source state
        tmr_evt_en = 1; evt_sel = 0;
        for (int s = 0; s < 2; s++) begin
            src_running = (s == 0);
            for (int m = 0; m < 8; m++) begin
                trig_mode = 3'(m);
                for (int k = 0; k < 3; k++) begin
                    int exp;
                    c0 = conv_cnt; h0 = srchigh_cnt;
                    if (k == 0) fire_timer();
                    else if (k == 1) pulse_sw();
                    else pulse_hw();
                    settle(30);
                    exp = ((k == 0 && m == 7) || (k == 1 && m == 0) ||
                           (k == 2 && m >= 1 && m <= 6)) ? 1 : 0;
                    check(conv_cnt - c0 == exp,
                          (m == 7) ? "R1 event mode" : (m == 0) ? "R3 software mode" : "R4 hardware mode",
                          conv_cnt - c0, exp);
                    if (src_running)
                        check(srchigh_cnt == h0, "R5 no source request when running",
                              srchigh_cnt - h0, 0);
                    else
                        check((srchigh_cnt > h0) == (exp == 1), "R5 source requested when stopped",
                              srchigh_cnt - h0, exp);
                end
            end
        end

        // R2: disabled timer and unselected sources
        trig_mode = 3'd7; src_running = 1;
        tmr_evt_en = 0; evt_sel = 0; c0 = conv_cnt;
        fire_timer(); settle(30);
        check(conv_cnt == c0, "R2 timer disabled", conv_cnt - c0, 0);
        tmr_evt_en = 1; evt_sel = 1; c0 = conv_cnt;
        fire_timer(); settle(30);
        check(conv_cnt == c0, "R2 timer unselected", conv_cnt - c0, 0);
        c0 = conv_cnt;
        fire_pwm(); settle(30);
        check(conv_cnt - c0 == 1, "R1 PWM event", conv_cnt - c0, 1);
        evt_sel = 0; c0 = conv_cnt;
        fire_pwm(); settle(30);
        check(conv_cnt == c0, "R2 PWM unselected", conv_cnt - c0, 0);

        // R5 R6 R10: stopped source, gate timing
        src_running = 0; busy_len = 6; c0 = conv_cnt;
        fire_timer();
        waited = 0;
        while (!conv_start && waited < 60) begin
            check(!mod_clk_en || src_ready, "R5 gate waits for ready", int'(mod_clk_en), 0);
            @(negedge clk); waited++;
        end
        check(conv_start && src_ready && mod_clk_en, "R5 start after ready",
              int'({conv_start, src_ready, mod_clk_en}), 7);
        @(negedge clk);
        check(!conv_start, "R10 start lasts one cycle", int'(conv_start), 0);
        settle(2);
        check(mod_clk_en && conv_busy, "R6 clock on while busy",
              int'({mod_clk_en, conv_busy}), 3);
        settle(20);
        check(!mod_clk_en && !src_req, "R6 gate and source off after busy",
              int'({mod_clk_en, src_req}), 0);
        check(conv_cnt - c0 == 1, "R10 one conversion", conv_cnt - c0, 1);

        // R7: trigger during an operation
        busy_len = 14; c0 = conv_cnt; f0 = srcfall_cnt;
        fire_timer();
        waited = 0;
        while (!conv_start && waited < 60) begin @(negedge clk); waited++; end
        settle(1);
        fire_timer();
        settle(70);
        check(conv_cnt - c0 == 2, "R7 queued trigger served", conv_cnt - c0, 2);
        check(srcfall_cnt - f0 == 1, "R7 source held across both", srcfall_cnt - f0, 1);

        // R8: wake only on interrupt
        busy_len = 3; src_running = 1;
        fire_timer(); settle(30);
        check(!wake, "R8 no wake without interrupt", int'(wake), 0);
        irq_on = 1;
        fire_timer(); settle(30);
        irq_on = 0;
        check(wake, "R8 wake after interrupt", int'(wake), 1);
        settle(10);
        check(wake, "R8 wake held", int'(wake), 1);
        @(negedge clk); wake_clr = 1; @(negedge clk); wake_clr = 0;
        settle(2);
        check(!wake, "R8 wake cleared", int'(wake), 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule